// File: doc/BRIEF.md
# Scan-Doubled Raster Streamer

This block produces a 640x480-class monitor raster from a 75 MHz clock and fills it with a 256x192 picture made of one-byte RGB332 pixels (red in bits 7:5, green in bits 4:2, blue in bits 1:0). Each pixel is held on the colour output for seven clocks to widen it. Each picture row takes two output lines. The first line carries the pixels. The second line is forced black, which gives a CRT-style scanline look.

The black line is also the render window. At the start of each such line the block pulses a row request with the number of the next picture row. An external renderer fills a one-row buffer and answers with a one-cycle acknowledge. Pixels are fetched from that buffer through a read port with a fixed latency of one cycle. The port has no back-pressure: the buffer must return the byte in the cycle after `pix_rd_en`, and the block never waits. A row whose acknowledge has not arrived by the time its pixel line starts is shown as a black line.

Positions are given as line L (0..524) and clock H (0..2383) within the line. While reset is held, the block rests at the last clock of the last line. The first clock edge after reset is released enters line 0, clock 0.

Top module: `raster_streamer`

## Requirements
- R1: A line lasts LINE_CLKS clocks (2384). `hsync_n` is low for clocks 0..HSYNC_CLKS-1 (0..285) and high otherwise. `line_start` is high only at clock 0.
- R2: A frame lasts 525 lines. `vsync_n` is low only on lines 490 and 491. `frame_start` is high only at line 0, clock 0.
- R3: `vblank` is high exactly on lines 480..524.
- R4: The picture window begins at active line 48, so the pixel line of row r is line 48+2r. Each row is requested on line 47+2r for r = 0..191: `row_req` is high for the single cycle at clock 0 of that line, with `row_num` = r.
- R5: On a shown pixel line, address k (k = 0..255) is presented with `pix_rd_en` at clock PIX_START+7k (PIX_START = 486). The byte returned in the following cycle drives `rgb` over clocks PIX_START+7k+2 through PIX_START+7k+8.
- R6: The load slot after the last pixel is always black. `rgb` is 0 from clock PIX_START+1794 to the end of the line. A shown line issues exactly 256 reads.
- R7: Every other line — the black line after each row, active lines outside the window, and all blanking lines — issues no reads and keeps `rgb` at 0.
- R8: A pixel line is shown only if `row_ack` was sampled high in some cycle from its request cycle through the last clock before that pixel line. An acknowledge at clock 0 of the pixel line is too late, and the line stays black with no reads.
- R9: During reset the outputs are `hsync_n`=1, `vsync_n`=1, `vblank`=1, `rgb`=0, and all strobes, `row_req` and `pix_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock, 75 MHz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_ack | input | 1 | One-cycle pulse: the requested row is in the buffer |
| pix_data | input | 8 | Row-buffer read data, valid one cycle after `pix_rd_en` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 8 | RGB332 colour byte |
| line_start | output | 1 | Pulse at clock 0 of every line |
| frame_start | output | 1 | Pulse at line 0, clock 0 |
| vblank | output | 1 | High on lines past the active area |
| row_req | output | 1 | One-cycle request for the next picture row |
| row_num | output | $clog2(SRC_ROWS) | Row number carried with `row_req` |
| pix_rd_en | output | 1 | Row-buffer read strobe |
| pix_addr | output | $clog2(SRC_COLS) | Row-buffer column address |

## Verification
The bench uses shortened timing parameters. It compares every output on every cycle against a behavioural raster model. The sharpest corner is the acknowledge window. One acknowledge lands on the last clock before its pixel line, and another lands on the first clock of it. A design with an off-by-one in flag sampling would show a stale or empty row, or drop a valid one. One row is never acknowledged, which catches a design that shows old buffer contents. The black closing slot and the two-cycle read-to-colour latency are checked at every pixel boundary, so a stray extra read, a missing stop or a colour that leaks onto the black line fails at once.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [1:0] {
    LK_BLANK = 2'd0,
    LK_FETCH = 2'd1,
    LK_SHOW  = 2'd2,
    LK_DARK  = 2'd3
  } line_kind_t;

  // Classify a line against the picture window. Rows sit on even offsets
  // from win; the black line before each row fetches it.
  function automatic line_kind_t classify(input int line, input int win, input int rows);
    int rel;
    rel = line - win;
    if (rel == -1) return LK_FETCH;
    if (rel < 0 || rel >= 2 * rows) return LK_BLANK;
    if ((rel % 2) == 0) return LK_SHOW;
    if (rel < 2 * rows - 1) return LK_FETCH;
    return LK_DARK;
  endfunction

endpackage

// File: rtl/raster_htimer.sv
module raster_htimer #(
  parameter int LINE_CLKS  = 2384,
  parameter int HSYNC_CLKS = 286,
  localparam int HW = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_pos,
  output logic          line_wrap,
  output logic          line_first,
  output logic          hsync_n
);

  logic [HW-1:0] h_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         h_q <= HW'(LINE_CLKS - 1);
    else if (line_wrap) h_q <= '0;
    else                h_q <= h_q + 1'b1;
  end

  assign h_pos      = h_q;
  assign line_wrap  = (h_q == HW'(LINE_CLKS - 1));
  assign line_first = (h_q == '0);
  assign hsync_n    = (h_q >= HW'(HSYNC_CLKS));

  // R1
  sync_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_first |-> !hsync_n);
  // R1
  line_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> line_first);

endmodule

// File: rtl/raster_vtimer.sv
module raster_vtimer #(
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_wrap,
  output logic [VW-1:0] v_pos,
  output logic [VW-1:0] v_next,
  output logic          vsync_n,
  output logic          vblank
);

  localparam int SYNC_FIRST = V_ACTIVE + V_FP;
  localparam int SYNC_END   = SYNC_FIRST + V_SYNC;

  logic [VW-1:0] v_q;

  always_comb begin
    v_next = v_q;
    if (line_wrap) begin
      if (v_q == VW'(V_TOTAL - 1)) v_next = '0;
      else                         v_next = v_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= VW'(V_TOTAL - 1);
    else        v_q <= v_next;
  end

  assign v_pos   = v_q;
  assign vsync_n = !((v_q >= VW'(SYNC_FIRST)) && (v_q < VW'(SYNC_END)));
  assign vblank  = (v_q >= VW'(V_ACTIVE));

  // R2
  vsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (v_q == VW'(SYNC_FIRST)));
  // R3
  blank_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> (v_q == VW'(V_ACTIVE)));

endmodule

// File: rtl/raster_rowseq.sv
module raster_rowseq
  import raster_pkg::*;
#(
  parameter int V_ACTIVE = 480,
  parameter int ROWS     = 192,
  parameter int VW       = 10,
  localparam int RW      = $clog2(ROWS),
  localparam int WIN     = (V_ACTIVE - 2 * ROWS) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_wrap,
  input  logic          line_first,
  input  logic [VW-1:0] v_pos,
  input  logic [VW-1:0] v_next,
  input  logic          row_ack,
  output logic          row_req,
  output logic [RW-1:0] row_num,
  output logic          show_line
);

  line_kind_t kind_now, kind_next;
  logic       have_row_q;
  logic       show_q;

  assign kind_now  = classify(int'(v_pos), WIN, ROWS);
  assign kind_next = classify(int'(v_next), WIN, ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_row_q <= 1'b0;
      show_q     <= 1'b0;
    end else begin
      if (line_wrap && kind_next == LK_FETCH) have_row_q <= 1'b0;
      else if (row_ack)                       have_row_q <= 1'b1;
      if (line_wrap) show_q <= (kind_next == LK_SHOW) && (have_row_q || row_ack);
    end
  end

  assign row_req   = line_first && (kind_now == LK_FETCH);
  assign row_num   = row_req ? RW'((int'(v_pos) + 1 - WIN) / 2) : '0;
  assign show_line = show_q;

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_req |=> !row_req);
  // R4
  req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_req |-> (v_pos < VW'(V_ACTIVE)));
  // R8
  show_only_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    show_line |-> (kind_now == LK_SHOW));

endmodule

// File: rtl/raster_pixpipe.sv
module raster_pixpipe #(
  parameter int PIX_START = 486,
  parameter int PIX_DIV   = 7,
  parameter int COLS      = 256,
  parameter int HW        = 12,
  localparam int AW       = $clog2(COLS),
  localparam int LOADS    = COLS + 1,
  localparam int CW       = $clog2(LOADS + 1),
  localparam int DW       = $clog2(PIX_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_pos,
  input  logic          show_line,
  input  logic [7:0]    pix_data,
  output logic          pix_rd_en,
  output logic [AW-1:0] pix_addr,
  output logic [7:0]    rgb
);

  logic          run_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] cnt_q;
  logic          start, tick, black_slot;
  logic [CW-1:0] idx;
  logic          load_q, fill_q;
  logic [7:0]    rgb_q;

  assign start      = (h_pos == HW'(PIX_START));
  assign tick       = start || (run_q && div_q == DW'(PIX_DIV - 1));
  assign idx        = start ? '0 : cnt_q;
  assign black_slot = (idx == CW'(COLS));
  assign pix_rd_en  = tick && !black_slot && show_line;
  assign pix_addr   = idx[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      div_q <= '0;
      cnt_q <= CW'(1);
    end else if (run_q) begin
      if (div_q == DW'(PIX_DIV - 1)) begin
        div_q <= '0;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(LOADS - 1)) run_q <= 1'b0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      fill_q <= 1'b0;
      rgb_q  <= '0;
    end else begin
      load_q <= tick;
      fill_q <= pix_rd_en;
      if (load_q) rgb_q <= fill_q ? pix_data : 8'h00;
    end
  end

  assign rgb = rgb_q;

  // R7
  rd_needs_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd_en |-> show_line);
  // R6
  stop_after_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && black_slot) |=> !run_q);
  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd_en |-> (idx < CW'(COLS)));

  generate
    if (PIX_DIV > 1) begin : g_spacing
      // R5
      rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rd_en |=> !pix_rd_en);
    end
  endgenerate

endmodule

// File: rtl/raster_streamer.sv
module raster_streamer #(
  parameter int LINE_CLKS  = 2384,
  parameter int HSYNC_CLKS = 286,
  parameter int PIX_START  = 486,
  parameter int PIX_DIV    = 7,
  parameter int SRC_COLS   = 256,
  parameter int SRC_ROWS   = 192,
  parameter int V_ACTIVE   = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 33,
  localparam int AW        = $clog2(SRC_COLS),
  localparam int RW        = $clog2(SRC_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_ack,
  input  logic [7:0]    pix_data,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [7:0]    rgb,
  output logic          line_start,
  output logic          frame_start,
  output logic          vblank,
  output logic          row_req,
  output logic [RW-1:0] row_num,
  output logic          pix_rd_en,
  output logic [AW-1:0] pix_addr
);

  localparam int HW      = $clog2(LINE_CLKS);
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int VW      = $clog2(V_TOTAL);

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos, v_next;
  logic          line_wrap, line_first, show_line;

  raster_htimer #(.LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS)) u_h (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_wrap(line_wrap),
    .line_first(line_first), .hsync_n(hsync_n)
  );

  raster_vtimer #(.V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)) u_v (
    .clk(clk), .rst_n(rst_n), .line_wrap(line_wrap), .v_pos(v_pos),
    .v_next(v_next), .vsync_n(vsync_n), .vblank(vblank)
  );

  raster_rowseq #(.V_ACTIVE(V_ACTIVE), .ROWS(SRC_ROWS), .VW(VW)) u_rows (
    .clk(clk), .rst_n(rst_n), .line_wrap(line_wrap), .line_first(line_first),
    .v_pos(v_pos), .v_next(v_next), .row_ack(row_ack), .row_req(row_req),
    .row_num(row_num), .show_line(show_line)
  );

  raster_pixpipe #(.PIX_START(PIX_START), .PIX_DIV(PIX_DIV), .COLS(SRC_COLS), .HW(HW)) u_pix (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .show_line(show_line),
    .pix_data(pix_data), .pix_rd_en(pix_rd_en), .pix_addr(pix_addr), .rgb(rgb)
  );

  assign line_start  = line_first;
  assign frame_start = line_first && (v_pos == '0);

  // R2
  frame_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && vsync_n));

endmodule

// File: tb/raster_streamer_test.sv
module raster_streamer_test;
  localparam int LINE = 80, HS = 10, PS = 15, DIV = 3, COLS = 16;
  localparam int VA = 24, VF = 2, VS = 2, VB = 3, ROWS = 8;
  localparam int VT  = VA + VF + VS + VB;
  localparam int WIN = (VA - 2 * ROWS) / 2;
  localparam int AW  = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam int FRAMES = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, row_ack;
  logic [7:0] pix_data, rgb;
  logic hsync_n, vsync_n, line_start, frame_start, vblank, row_req, pix_rd_en;
  logic [RW-1:0] row_num;
  logic [AW-1:0] pix_addr;

  raster_streamer #(
    .LINE_CLKS(LINE), .HSYNC_CLKS(HS), .PIX_START(PS), .PIX_DIV(DIV),
    .SRC_COLS(COLS), .SRC_ROWS(ROWS), .V_ACTIVE(VA), .V_FP(VF),
    .V_SYNC(VS), .V_BP(VB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .row_ack(row_ack), .pix_data(pix_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb), .line_start(line_start),
    .frame_start(frame_start), .vblank(vblank), .row_req(row_req),
    .row_num(row_num), .pix_rd_en(pix_rd_en), .pix_addr(pix_addr)
  );

  int total = 0, bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_fetch(input int v);
    return (v >= WIN - 1) && (v < WIN - 1 + 2 * ROWS) && (((v - WIN + 1) % 2) == 0);
  endfunction

  function automatic bit is_show(input int v);
    return (v >= WIN) && (v < WIN + 2 * ROWS) && (((v - WIN) % 2) == 0);
  endfunction

  function automatic int pixval(input int row, input int k);
    return (row * 37 + k * 11 + 5) % 256;
  endfunction

  int mh, mv, frame, buf_row, exp_rgb, rd_count, ack_at, ack_row, cyc;
  bit flag, show, ack_now, s_rd, cur_shown;
  int s_addr;
  int rdc [FRAMES * ROWS];

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; row_ack = 1'b0; pix_data = 8'h00;
    mh = LINE - 1; mv = VT - 1; frame = -1; buf_row = 0; exp_rgb = 0;
    rd_count = 0; ack_at = -1; ack_row = 0; cyc = 0;
    flag = 0; show = 0; ack_now = 0; s_rd = 0; s_addr = 0; cur_shown = 0;
    foreach (rdc[i]) rdc[i] = -1;

    repeat (3) @(negedge clk);
    chk("R9", "reset hsync_n", int'(hsync_n), 1);
    chk("R9", "reset vsync_n", int'(vsync_n), 1);
    chk("R9", "reset vblank", int'(vblank), 1);
    chk("R9", "reset rgb", int'(rgb), 0);
    chk("R9", "reset strobes", int'({line_start, frame_start, row_req, pix_rd_en}), 0);
    rst_n = 1'b1;

    for (int c = 0; c < FRAMES * VT * LINE; c++) begin
      @(posedge clk);
      #1;
      if (mh == LINE - 1) begin
        // close out the line just finished
        if (cur_shown) chk("R6", "reads on shown line", rd_count, COLS);
        else           chk("R7", "reads on dark line", rd_count, 0);
        if (is_show(mv) && frame >= 0 && frame < FRAMES)
          rdc[frame * ROWS + (mv - WIN) / 2] = rd_count;
        rd_count = 0;
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
        if (mv == 0) frame++;
        if (is_show(mv)) show = flag | ack_now;
        if (is_fetch(mv)) flag = 0;
        else if (ack_now) flag = 1;
      end else begin
        mh++;
        if (ack_now) flag = 1;
      end
      cur_shown = is_show(mv) && show;
      if (s_rd) pix_data = 8'(pixval(buf_row, s_addr));
      if (mh >= PS + 2 && ((mh - PS - 2) % DIV) == 0 && ((mh - PS - 2) / DIV) <= COLS) begin
        int k;
        k = (mh - PS - 2) / DIV;
        exp_rgb = (cur_shown && k < COLS) ? pixval(buf_row, k) : 0;
      end

      @(negedge clk);
      cyc++;
      chk("R1", "hsync_n", int'(hsync_n), int'(mh >= HS));
      chk("R1", "line_start", int'(line_start), int'(mh == 0));
      chk("R2", "vsync_n", int'(vsync_n), int'(!(mv >= VA + VF && mv < VA + VF + VS)));
      chk("R2", "frame_start", int'(frame_start), int'(mh == 0 && mv == 0));
      chk("R3", "vblank", int'(vblank), int'(mv >= VA));
      chk("R4", "row_req", int'(row_req), int'(mh == 0 && is_fetch(mv)));
      if (mh == 0 && is_fetch(mv)) begin
        int r;
        r = (mv - WIN + 1) / 2;
        chk("R4", "row_num", int'(row_num), r);
        ack_row = r;
        if (frame == 0 && r == 2)      ack_at = -1;
        else if (frame == 0 && r == 3) ack_at = cyc + LINE;
        else if (r == 6)               ack_at = cyc + LINE - 1;
        else                           ack_at = cyc + 4;
      end
      begin
        bit rd_exp;
        rd_exp = cur_shown && mh >= PS && ((mh - PS) % DIV) == 0 && ((mh - PS) / DIV) < COLS;
        chk(cur_shown ? "R5" : "R7", "pix_rd_en", int'(pix_rd_en), int'(rd_exp));
        if (rd_exp && pix_rd_en) chk("R5", "pix_addr", int'(pix_addr), (mh - PS) / DIV);
      end
      chk(!cur_shown ? "R7" : (mh >= PS + 2 + DIV * COLS ? "R6" : "R5"), "rgb", int'(rgb), exp_rgb);
      s_rd = pix_rd_en;
      s_addr = int'(pix_addr);
      if (pix_rd_en) rd_count++;
      row_ack = 1'b0;
      if (cyc == ack_at) begin
        row_ack = 1'b1;
        buf_row = ack_row;
        ack_at = -1;
      end
      ack_now = row_ack;
    end

    // R8: missing and one-cycle-late acknowledges blank the row; last-clock ack shows it
    chk("R8", "row 2 never acked, reads", rdc[2], 0);
    chk("R8", "row 3 acked late, reads", rdc[3], 0);
    chk("R8", "row 6 acked on last clock, reads", rdc[6], COLS);
    chk("R8", "row 2 acked next frame, reads", rdc[ROWS + 2], COLS);
    chk("R8", "row 3 acked next frame, reads", rdc[ROWS + 3], COLS);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule